// File: doc/BRIEF.md
# Zone Access Map State Table

This block keeps a small set-associative table of memory zones for a spatial prefetcher. Every entry covers one aligned zone of consecutive cache lines and records a 2-bit state for each line in it. An accepted request names a byte address and a secure flag. The table finds or allocates the entry for that zone and for both adjacent zones. It marks the requested line as accessed and returns all three line maps one cycle later, so a pattern matcher can search them for strides.

A separate mark port lets the pattern matcher record a line it has chosen to prefetch. Each line state change is turned into a single-cycle event pulse for a statistics block that counts issued prefetches, raw misses, good prefetches and raw hits. The lookup key is the zone number together with the secure flag, so the two address spaces never share an entry. Mark and request share the table write path. A mark therefore holds off requests for the cycle in which it is presented.

Top module: `zam_table`

## Requirements
- R1: The zone number is `req_addr[31:10]` and the line index is `req_addr[9:6]`; bits below 6 do not affect the result.
- R2: After a synchronous active-low reset, `rsp_valid` and all event pulses are low and the table holds no entries, so the first access to any zone allocates.
- R3: One cycle after a request is accepted, `rsp_valid` is high and `rsp_map_curr` shows the requested line as accessed. Line states are encoded init=0, prefetched=1, accessed=2, invalid=3, and line i sits at bits [2i+1:2i]. A freshly allocated entry has every other line at init, and the access raises `ev_miss`.
- R4: Accessing a line that is already accessed raises `ev_hit`, leaves the map unchanged and raises no other event.
- R5: A mark on an init line of a resident entry sets the line to prefetched and raises `ev_issued` one cycle later. A later access to that line raises `ev_good`.
- R6: A mark on a line that is not init, or on a zone that is not resident, changes no state, allocates nothing and raises no event.
- R7: The same zone number with a different secure flag is a separate entry.
- R8: `rsp_map_prev` and `rsp_map_next` show the state of the adjacent zones after the lookup. When a neighbour does not exist (the previous zone of zone 0, or the next zone of the top zone), its map is all ones (every line invalid).
- R9: Each set has two ways. Allocation uses an empty way first, and otherwise evicts the least recently used way. A hit on the current zone or on a neighbour zone refreshes the use order.
- R10: `req_ready` is low whenever `mark_valid` is high, and a request presented then is not accepted.
- R11: Every response carries exactly one of `ev_miss`, `ev_good` and `ev_hit`. None of the three is raised without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_secure | input | 1 | Secure address space flag |
| mark_valid | input | 1 | Record a chosen prefetch line |
| mark_zone | input | 22 | Zone number of the marked line |
| mark_secure | input | 1 | Secure flag of the marked line |
| mark_line | input | 4 | Line index within the marked zone |
| rsp_valid | output | 1 | Maps below are valid this cycle |
| rsp_map_prev | output | 32 | Line states of the previous zone |
| rsp_map_curr | output | 32 | Line states of the current zone |
| rsp_map_next | output | 32 | Line states of the next zone |
| ev_issued | output | 1 | Pulse: init to prefetched |
| ev_miss | output | 1 | Pulse: init to accessed |
| ev_good | output | 1 | Pulse: prefetched to accessed |
| ev_hit | output | 1 | Pulse: accessed to accessed |

## Verification
The assertions assume that a request is accepted only when both `req_valid` and `req_ready` are high. They also assume that marks and requests never write in the same cycle, so that the response and its single event always come from the request of the previous cycle. The bench never holds a request across cycles: it presents each one for exactly one cycle. It resets the table before every scenario, so that set occupancy, and with it which way is evicted, follows only from that scenario's own accesses and their neighbour lookups. One scenario presents a request and a mark together on purpose, to confirm that the request is dropped rather than queued.

// File: rtl/zam_pkg.sv
// Shared types for the zone access map table.
// Assumes two ways per set (one replacement bit per set).
package zam_pkg;
    localparam int ZAM_WAYS = 2;

    typedef enum logic [1:0] {
        LS_INIT = 2'd0,
        LS_PREF = 2'd1,
        LS_ACC  = 2'd2,
        LS_INV  = 2'd3
    } line_state_e;
endpackage

// File: rtl/zam_way_pick.sv
// Tag compare and victim choice for one set of the zone table.
// Assumes ZAM_WAYS == 2: lru_way names the way to evict when both are valid.
module zam_way_pick #(
    parameter int TAG_W = 20
) (
    input  logic [zam_pkg::ZAM_WAYS-1:0]       way_valid,
    input  logic [zam_pkg::ZAM_WAYS-1:0]       way_secure,
    input  logic [zam_pkg::ZAM_WAYS*TAG_W-1:0] way_tags,
    input  logic                               lru_way,
    input  logic [TAG_W-1:0]                   key_tag,
    input  logic                               key_secure,
    output logic                               hit,
    output logic                               way
);
    // Find a matching way, else the first empty way, else the LRU way.
    always_comb begin
        logic found_free;
        logic free_way;
        hit        = 1'b0;
        way        = lru_way;
        found_free = 1'b0;
        free_way   = 1'b0;
        for (int w = zam_pkg::ZAM_WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                found_free = 1'b1;
                free_way   = w[0];
            end
        end
        if (found_free) way = free_way;
        for (int w = 0; w < zam_pkg::ZAM_WAYS; w++) begin
            if (way_valid[w] && way_secure[w] == key_secure &&
                way_tags[w*TAG_W +: TAG_W] == key_tag && !hit) begin
                hit = 1'b1;
                way = w[0];
            end
        end
    end
endmodule

// File: rtl/zam_event_class.sv
// Turns one line state transition into a statistics pulse.
// Writing init, or a transition not listed, produces no pulse.
module zam_event_class (
    input  logic                 en,
    input  zam_pkg::line_state_e old_st,
    input  zam_pkg::line_state_e new_st,
    output logic                 issued,
    output logic                 miss,
    output logic                 good,
    output logic                 hit
);
    import zam_pkg::*;

    // Decode the transition into one of four counters.
    always_comb begin
        issued = en && old_st == LS_INIT && new_st == LS_PREF;
        miss   = en && old_st == LS_INIT && new_st == LS_ACC;
        good   = en && old_st == LS_PREF && new_st == LS_ACC;
        hit    = en && old_st == LS_ACC  && new_st == LS_ACC;
    end
endmodule

// File: rtl/zam_table.sv
// Zone access map table: a set-associative store of per-line 2-bit states,
// keyed by zone number and secure flag. An accepted request looks up (and
// allocates on miss) the current zone and both neighbours, marks the current
// line accessed, and returns the three maps plus one event a cycle later.
// Assumes ZAM_WAYS == 2, SETS >= 3 so the three zones fall in distinct sets,
// and power-of-two line and zone sizes.
module zam_table #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int ZONE_LINES = 16,
    parameter int SETS       = 4,
    localparam int LINE_OFF_W = $clog2(LINE_BYTES),
    localparam int LINE_IDX_W = $clog2(ZONE_LINES),
    localparam int ZONE_OFF_W = LINE_OFF_W + LINE_IDX_W,
    localparam int ZONE_W     = ADDR_W - ZONE_OFF_W,
    localparam int MAP_W      = 2 * ZONE_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_secure,
    input  logic                  mark_valid,
    input  logic [ZONE_W-1:0]     mark_zone,
    input  logic                  mark_secure,
    input  logic [LINE_IDX_W-1:0] mark_line,
    output logic                  rsp_valid,
    output logic [MAP_W-1:0]      rsp_map_prev,
    output logic [MAP_W-1:0]      rsp_map_curr,
    output logic [MAP_W-1:0]      rsp_map_next,
    output logic                  ev_issued,
    output logic                  ev_miss,
    output logic                  ev_good,
    output logic                  ev_hit
);
    import zam_pkg::*;

    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ZONE_W - SET_W;
    localparam int WAYS   = ZAM_WAYS;
    localparam int SLOTS  = 4;   // 0 prev, 1 curr, 2 next, 3 mark
    localparam int SLOT_MARK = 3;

    // Table storage.
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  sec_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [MAP_W-1:0] map_q [SETS][WAYS];
    logic             lru_q [SETS];

    logic [ZONE_W-1:0]     req_zone;
    logic [LINE_IDX_W-1:0] req_line;
    logic                  fire;

    logic [ZONE_W-1:0]     slot_zone [SLOTS];
    logic                  slot_sec  [SLOTS];
    logic                  slot_here [SLOTS];
    logic [SET_W-1:0]      slot_set  [SLOTS];
    logic [WAYS*TAG_W-1:0] slot_tags [SLOTS];
    logic                  slot_hit  [SLOTS];
    logic                  slot_way  [SLOTS];
    logic [MAP_W-1:0]      old_map   [3];
    logic [MAP_W-1:0]      new_map   [3];

    line_state_e acc_old, mark_old;
    logic        mark_apply;
    logic        a_iss, a_miss, a_good, a_hit;
    logic        m_iss, m_miss, m_good, m_hit;

    // Split the request address and gate acceptance on the mark port.
    always_comb begin
        req_zone  = req_addr[ADDR_W-1:ZONE_OFF_W];
        req_line  = req_addr[ZONE_OFF_W-1:LINE_OFF_W];
        req_ready = !mark_valid;
        fire      = req_valid && req_ready;
    end

    // Form the key, presence and set index of each lookup slot.
    always_comb begin
        slot_zone[0] = req_zone - 1'b1;
        slot_zone[1] = req_zone;
        slot_zone[2] = req_zone + 1'b1;
        slot_zone[3] = mark_zone;
        slot_here[0] = req_zone != '0;
        slot_here[1] = 1'b1;
        slot_here[2] = req_zone != '1;
        slot_here[3] = 1'b1;
        for (int k = 0; k < SLOTS; k++) begin
            slot_sec[k] = (k == SLOT_MARK) ? mark_secure : req_secure;
            slot_set[k] = slot_zone[k][SET_W-1:0];
            for (int w = 0; w < WAYS; w++)
                slot_tags[k][w*TAG_W +: TAG_W] = tag_q[slot_set[k]][w];
        end
    end

    // One tag comparator per lookup slot.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        zam_way_pick #(.TAG_W(TAG_W)) u_pick (
            .way_valid  (vld_q[slot_set[k]]),
            .way_secure (sec_q[slot_set[k]]),
            .way_tags   (slot_tags[k]),
            .lru_way    (lru_q[slot_set[k]]),
            .key_tag    (slot_zone[k][ZONE_W-1:SET_W]),
            .key_secure (slot_sec[k]),
            .hit        (slot_hit[k]),
            .way        (slot_way[k])
        );
    end

    // Build the maps seen before and after the access.
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            if (!slot_here[k])     old_map[k] = '1;
            else if (slot_hit[k])  old_map[k] = map_q[slot_set[k]][slot_way[k]];
            else                   old_map[k] = '0;
            new_map[k] = old_map[k];
        end
        acc_old = line_state_e'(old_map[1][{req_line, 1'b0} +: 2]);
        new_map[1][{req_line, 1'b0} +: 2] = LS_ACC;
    end

    // Decide whether a mark may turn an init line into prefetched.
    always_comb begin
        mark_old   = line_state_e'(map_q[slot_set[SLOT_MARK]][slot_way[SLOT_MARK]]
                                         [{mark_line, 1'b0} +: 2]);
        mark_apply = mark_valid && slot_hit[SLOT_MARK] && mark_old == LS_INIT;
    end

    zam_event_class u_acc_ev (
        .en(fire), .old_st(acc_old), .new_st(LS_ACC),
        .issued(a_iss), .miss(a_miss), .good(a_good), .hit(a_hit)
    );

    zam_event_class u_mark_ev (
        .en(mark_apply), .old_st(mark_old), .new_st(LS_PREF),
        .issued(m_iss), .miss(m_miss), .good(m_good), .hit(m_hit)
    );

    // Register responses and events, and write the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            ev_issued    <= 1'b0;
            ev_miss      <= 1'b0;
            ev_good      <= 1'b0;
            ev_hit       <= 1'b0;
            rsp_map_prev <= '0;
            rsp_map_curr <= '0;
            rsp_map_next <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                sec_q[s] <= '0;
                lru_q[s] <= 1'b0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    map_q[s][w] <= '0;
                end
            end
        end else begin
            rsp_valid <= fire;
            ev_issued <= a_iss || m_iss;
            ev_miss   <= a_miss || m_miss;
            ev_good   <= a_good || m_good;
            ev_hit    <= a_hit || m_hit;
            if (fire) begin
                rsp_map_prev <= new_map[0];
                rsp_map_curr <= new_map[1];
                rsp_map_next <= new_map[2];
                for (int k = 0; k < 3; k++) begin
                    if (slot_here[k]) begin
                        vld_q[slot_set[k]][slot_way[k]] <= 1'b1;
                        sec_q[slot_set[k]][slot_way[k]] <= req_secure;
                        tag_q[slot_set[k]][slot_way[k]] <= slot_zone[k][ZONE_W-1:SET_W];
                        map_q[slot_set[k]][slot_way[k]] <= new_map[k];
                        lru_q[slot_set[k]] <= !slot_way[k];
                    end
                end
            end else if (mark_apply) begin
                map_q[slot_set[SLOT_MARK]][slot_way[SLOT_MARK]][{mark_line, 1'b0} +: 2] <= LS_PREF;
            end
        end
    end
endmodule

// File: rtl/zam_table_chk.sv
// Property checker for zam_table, attached by bind below.
// Tracks the last accepted request to relate it to the next response.
module zam_table_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int ZONE_LINES = 16,
    localparam int LINE_OFF_W = $clog2(LINE_BYTES),
    localparam int LINE_IDX_W = $clog2(ZONE_LINES),
    localparam int ZONE_OFF_W = LINE_OFF_W + LINE_IDX_W,
    localparam int ZONE_W     = ADDR_W - ZONE_OFF_W,
    localparam int MAP_W      = 2 * ZONE_LINES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mark_valid,
    input logic              rsp_valid,
    input logic [MAP_W-1:0]  rsp_map_prev,
    input logic [MAP_W-1:0]  rsp_map_curr,
    input logic [MAP_W-1:0]  rsp_map_next,
    input logic              ev_issued,
    input logic              ev_miss,
    input logic              ev_good,
    input logic              ev_hit
);
    logic [LINE_IDX_W-1:0] last_line_q;
    logic [ZONE_W-1:0]     last_zone_q;
    logic [1:0]            cur_state;

    // Remember the zone and line of the most recent request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_line_q <= '0;
            last_zone_q <= '0;
        end else if (req_valid && req_ready) begin
            last_line_q <= req_addr[ZONE_OFF_W-1:LINE_OFF_W];
            last_zone_q <= req_addr[ADDR_W-1:ZONE_OFF_W];
        end
    end

    // Pick the reported state of the requested line.
    always_comb cur_state = rsp_map_curr[{last_line_q, 1'b0} +: 2];

    p_rsp_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_curr_line_accessed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cur_state == 2'd2);

    p_ready_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mark_valid |-> !req_ready);

    p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({ev_miss, ev_good, ev_hit}) == 1);

    p_quiet_events_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(ev_miss || ev_good || ev_hit));

    p_issue_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_issued |-> !rsp_valid);

    p_zone0_prev_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_zone_q == '0) |-> &rsp_map_prev);

    p_top_next_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && &last_zone_q) |-> &rsp_map_next);
endmodule

bind zam_table zam_table_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ZONE_LINES(ZONE_LINES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mark_valid(mark_valid), .rsp_valid(rsp_valid),
    .rsp_map_prev(rsp_map_prev), .rsp_map_curr(rsp_map_curr),
    .rsp_map_next(rsp_map_next), .ev_issued(ev_issued), .ev_miss(ev_miss),
    .ev_good(ev_good), .ev_hit(ev_hit)
);

// File: tb/zam_table_tb_top.sv
// Directed bench for zam_table: one task per scenario, reset before each.
module zam_table_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_secure = 1'b0;
    logic        mark_valid = 1'b0;
    logic [21:0] mark_zone = '0;
    logic        mark_secure = 1'b0;
    logic [3:0]  mark_line = '0;
    logic        rsp_valid;
    logic [31:0] rsp_map_prev, rsp_map_curr, rsp_map_next;
    logic        ev_issued, ev_miss, ev_good, ev_hit;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] E_MISS = 3'b100;
    localparam logic [2:0] E_GOOD = 3'b010;
    localparam logic [2:0] E_HIT  = 3'b001;
    localparam logic [31:0] ALL_INV = 32'hFFFF_FFFF;

    always #10 clk = ~clk;

    zam_table dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_secure(req_secure), .mark_valid(mark_valid),
        .mark_zone(mark_zone), .mark_secure(mark_secure), .mark_line(mark_line),
        .rsp_valid(rsp_valid), .rsp_map_prev(rsp_map_prev),
        .rsp_map_curr(rsp_map_curr), .rsp_map_next(rsp_map_next),
        .ev_issued(ev_issued), .ev_miss(ev_miss), .ev_good(ev_good), .ev_hit(ev_hit)
    );

    function automatic logic [31:0] acc_at(int line);
        return 32'd2 << (2 * line);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        mark_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one request for one cycle; outputs are sampled afterwards.
    task automatic do_req(logic [21:0] zone, int line, logic sec, int offs);
        @(negedge clk);
        req_addr   = {zone, line[3:0], 6'd0} | offs;
        req_secure = sec;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic do_mark(logic [21:0] zone, int line, logic sec);
        @(negedge clk);
        mark_zone   = zone;
        mark_line   = line[3:0];
        mark_secure = sec;
        mark_valid  = 1'b1;
        @(negedge clk);
        mark_valid  = 1'b0;
    endtask

    task automatic expect_rsp(string req, logic [2:0] ev,
                              logic [31:0] p, logic [31:0] c, logic [31:0] n);
        check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " events R11"}, {29'd0, ev_miss, ev_good, ev_hit}, {29'd0, ev});
        check({req, " prev map"}, rsp_map_prev, p);
        check({req, " curr map"}, rsp_map_curr, c);
        check({req, " next map"}, rsp_map_next, n);
    endtask

    task automatic t_reset();   // R2
        do_reset();
        check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R2 events", {28'd0, ev_issued, ev_miss, ev_good, ev_hit}, 32'd0);
        do_req(22'd9, 0, 1'b0, 0);
        expect_rsp("R2 empty table", E_MISS, 32'd0, acc_at(0), 32'd0);
    endtask

    task automatic t_first_access();   // R1 R3 R4
        do_reset();
        do_req(22'd5, 3, 1'b0, 6'h25);
        expect_rsp("R1 R3 first access", E_MISS, 32'd0, acc_at(3), 32'd0);
        do_req(22'd5, 3, 1'b0, 0);
        expect_rsp("R4 repeat access", E_HIT, 32'd0, acc_at(3), 32'd0);
    endtask

    task automatic t_neighbours();   // R8
        do_reset();
        do_req(22'd5, 3, 1'b0, 0);
        do_req(22'd6, 0, 1'b0, 0);
        expect_rsp("R8 prev resident", E_MISS, acc_at(3), acc_at(0), 32'd0);
        do_req(22'd4, 15, 1'b0, 0);
        expect_rsp("R8 next resident", E_MISS, 32'd0, acc_at(15), acc_at(3));
        do_req(22'd0, 2, 1'b0, 0);
        expect_rsp("R8 zone zero", E_MISS, ALL_INV, acc_at(2), 32'd0);
        do_req(22'h3F_FFFF, 15, 1'b0, 0);
        expect_rsp("R8 top zone", E_MISS, 32'd0, acc_at(15), ALL_INV);
    endtask

    task automatic t_mark();   // R5
        do_reset();
        do_req(22'd5, 3, 1'b0, 0);
        do_mark(22'd5, 7, 1'b0);
        check("R5 issued on mark", {31'd0, ev_issued}, 32'd1);
        do_req(22'd5, 7, 1'b0, 0);
        expect_rsp("R5 good prefetch", E_GOOD, 32'd0, acc_at(3) | acc_at(7), 32'd0);
        do_mark(22'd6, 0, 1'b0);
        check("R5 issued on neighbour", {31'd0, ev_issued}, 32'd1);
        do_req(22'd6, 0, 1'b0, 0);
        expect_rsp("R5 neighbour good", E_GOOD, acc_at(3) | acc_at(7), acc_at(0), 32'd0);
    endtask

    task automatic t_mark_ignored();   // R6
        do_reset();
        do_req(22'd5, 3, 1'b0, 0);
        do_mark(22'd5, 3, 1'b0);
        check("R6 accessed line mark", {31'd0, ev_issued}, 32'd0);
        do_mark(22'd50, 0, 1'b0);
        check("R6 absent zone mark", {31'd0, ev_issued}, 32'd0);
        do_req(22'd5, 3, 1'b0, 0);
        expect_rsp("R6 line kept accessed", E_HIT, 32'd0, acc_at(3), 32'd0);
        do_req(22'd50, 0, 1'b0, 0);
        expect_rsp("R6 no allocation", E_MISS, 32'd0, acc_at(0), 32'd0);
    endtask

    task automatic t_secure();   // R7
        do_reset();
        do_req(22'd5, 3, 1'b0, 0);
        do_req(22'd5, 3, 1'b1, 0);
        expect_rsp("R7 other space", E_MISS, 32'd0, acc_at(3), 32'd0);
        do_req(22'd5, 3, 1'b0, 0);
        expect_rsp("R7 first space kept", E_HIT, 32'd0, acc_at(3), 32'd0);
    endtask

    task automatic t_replace();   // R9
        do_reset();
        do_req(22'd20, 0, 1'b0, 0);
        do_req(22'd24, 0, 1'b0, 0);
        do_req(22'd20, 0, 1'b0, 0);
        expect_rsp("R9 hit refresh", E_HIT, 32'd0, acc_at(0), 32'd0);
        do_req(22'd28, 0, 1'b0, 0);
        expect_rsp("R9 third zone", E_MISS, 32'd0, acc_at(0), 32'd0);
        do_req(22'd20, 0, 1'b0, 0);
        check("R9 recent kept", {29'd0, ev_miss, ev_good, ev_hit}, {29'd0, E_HIT});
        do_req(22'd24, 0, 1'b0, 0);
        check("R9 lru evicted", {29'd0, ev_miss, ev_good, ev_hit}, {29'd0, E_MISS});
    endtask

    task automatic t_ready();   // R10
        do_reset();
        @(negedge clk);
        req_addr   = {22'd5, 4'd3, 6'd0};
        req_secure = 1'b0;
        req_valid  = 1'b1;
        mark_zone  = 22'd50;
        mark_line  = 4'd0;
        mark_valid = 1'b1;
        #1;
        check("R10 ready low", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        req_valid  = 1'b0;
        mark_valid = 1'b0;
        check("R10 no response", {31'd0, rsp_valid}, 32'd0);
        do_req(22'd5, 3, 1'b0, 0);
        expect_rsp("R10 request dropped", E_MISS, 32'd0, acc_at(3), 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_first_access();
        t_neighbours();
        t_mark();
        t_mark_ignored();
        t_secure();
        t_replace();
        t_ready();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule